// File: doc/BRIEF.md
# Trap Status-Word Adjuster

When the processor enters the non-allowed-operation trap location (X'40'), it loads a fresh 32-bit program status word. This block adjusts that word before it takes effect. Each reported trap cause sets its own condition-code bit. If the address-increment control of the exchange instruction is set, each cause also adds a fixed binary weight to the 17-bit next-instruction field. Causes that occur together therefore combine by addition. A software handler can use the condition codes to find the cause and use the advanced address to skip over the offending instruction.

For any other kind of exchange, the status word passes through unchanged. A valid strobe launches one adjustment. The result is registered on the next clock edge and is marked by a one-cycle done pulse. Bit numbering follows the machine convention: bit 0 is the most significant bit.

Top module: `trap_psw_adjust`

## Requirements
- R1: When trap40_i is low, psw_o takes the value of psw_i unchanged, whatever the cause flags and instruction word.
- R2: On a trap to X'40' with bad_instr_i high, status bit 0 (psw_o[31], CC1) is set. If AI is set, 8 is added to the next-instruction field (status bits 15-31, psw_o[16:0]).
- R3: On a trap to X'40' with bad_mem_i high, status bit 1 (psw_o[30], CC2) is set. If AI is set, 4 is added to the next-instruction field.
- R4: On a trap to X'40' with priv_i high, status bit 2 (psw_o[29], CC3) is set. If AI is set, 2 is added to the next-instruction field.
- R5: On a trap to X'40' with prot_i high, status bit 3 (psw_o[28], CC4) is set. If AI is set, 1 is added to the next-instruction field.
- R6: Causes that occur together set all of their condition-code bits and add the sum of their weights. For example, the nonexistent-and-privileged opcode case (bad_instr_i and priv_i) sets CC1 and CC3 and adds 10.
- R7: AI is bit 9 of the exchange instruction word, counted MSB-first, which is xinstr_i[22]. When AI is clear, the next-instruction field is unchanged. All other instruction bits have no effect.
- R8: The increment wraps modulo 2^17 inside psw_o[16:0]. Status bits 4-14 (psw_o[27:17]) always equal those of psw_i, and no carry reaches them.
- R9: psw_o is loaded on the clock edge after valid_i is high and holds otherwise. done_o is high for exactly the cycle after each valid cycle.
- R10: While rst_ni is low, psw_o is zero and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Launch one adjustment |
| psw_i | input | 32 | Newly loaded status word |
| xinstr_i | input | 32 | Exchange instruction word (AI in bit 9, MSB-first) |
| trap40_i | input | 1 | Exchange is the result of a trap to X'40' |
| bad_instr_i | input | 1 | Cause: nonexistent instruction |
| bad_mem_i | input | 1 | Cause: nonexistent memory address |
| priv_i | input | 1 | Cause: privileged instruction in slave mode |
| prot_i | input | 1 | Cause: memory protection violation |
| psw_o | output | 32 | Adjusted status word, registered |
| done_o | output | 1 | One-cycle pulse: psw_o is updated |

## Verification
The assertions assume that every input is stable and known around each rising edge. They also assume that the cause flags are meaningful only while valid_i is high, so they look only at cycles that follow a valid strobe, apart from the hold check.

The bench changes inputs only just after the falling edge. It drives arbitrary cause combinations, including sets that real trap logic would not raise together. This is allowed because the block adds the weights without any precondition on which causes may coincide.

// File: rtl/trap_psw_pkg.sv
package trap_psw_pkg;
  localparam int unsigned PSW_W  = 32;
  localparam int unsigned ADDR_W = 17;
  localparam int unsigned NCAUSE = 4;
  localparam int unsigned AI_POS = 9;

  // machine bit numbering: bit 0 is the MSB
  function automatic int unsigned msb_idx(int unsigned width, int unsigned pos);
    return width - 1 - pos;
  endfunction
endpackage

// File: rtl/trap_cc_merge.sv
module trap_cc_merge #(
  parameter int unsigned PSW_W  = 32,
  parameter int unsigned NCAUSE = 4
) (
  input  logic [PSW_W-1:0]  psw_i,
  input  logic [NCAUSE-1:0] cause_i,
  input  logic              en_i,
  output logic [PSW_W-1:0]  psw_o
);
  logic [PSW_W-1:0] mask;

  // cause k maps to CC bit k (MSB-first)
  for (genvar b = 0; b < PSW_W; b++) begin : g_mask
    if (b >= PSW_W - NCAUSE) begin : g_cc
      assign mask[b] = en_i & cause_i[PSW_W-1-b];
    end else begin : g_zero
      assign mask[b] = 1'b0;
    end
  end

  assign psw_o = psw_i | mask;
endmodule

// File: rtl/trap_addr_step.sv
module trap_addr_step #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned NCAUSE = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NCAUSE-1:0] cause_i,
  input  logic              en_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] part [NCAUSE];
  logic [ADDR_W-1:0] step;

  // cause k weighs 2^(NCAUSE-1-k)
  for (genvar k = 0; k < NCAUSE; k++) begin : g_part
    assign part[k] = (en_i && cause_i[k]) ? (ADDR_W'(1) << (NCAUSE - 1 - k)) : '0;
  end

  always_comb begin
    step = '0;
    for (int k = 0; k < NCAUSE; k++) step = step + part[k];
  end

  assign addr_o = addr_i + step;  // wraps within the field
endmodule

// File: rtl/trap_psw_adjust.sv
module trap_psw_adjust
  import trap_psw_pkg::*;
#(
  parameter int unsigned PW = PSW_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NC = NCAUSE,
  parameter int unsigned AI = AI_POS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [PW-1:0] psw_i,
  input  logic [PW-1:0] xinstr_i,
  input  logic          trap40_i,
  input  logic          bad_instr_i,
  input  logic          bad_mem_i,
  input  logic          priv_i,
  input  logic          prot_i,
  output logic [PW-1:0] psw_o,
  output logic          done_o
);
  localparam int unsigned AI_BIT = msb_idx(PW, AI);

  logic [NC-1:0] cause;
  logic          ai;
  logic [PW-1:0] cc_psw;
  logic [AW-1:0] addr_nxt;
  logic [PW-1:0] adj_psw;

  assign cause = {prot_i, priv_i, bad_mem_i, bad_instr_i};
  assign ai    = xinstr_i[AI_BIT];

  trap_cc_merge #(.PSW_W(PW), .NCAUSE(NC)) u_cc (
    .psw_i  (psw_i),
    .cause_i(cause),
    .en_i   (trap40_i),
    .psw_o  (cc_psw)
  );

  trap_addr_step #(.ADDR_W(AW), .NCAUSE(NC)) u_step (
    .addr_i (psw_i[AW-1:0]),
    .cause_i(cause),
    .en_i   (trap40_i & ai),
    .addr_o (addr_nxt)
  );

  assign adj_psw = {cc_psw[PW-1:AW], addr_nxt};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) psw_o <= adj_psw;
    end
  end

  // past_ok: one edge seen since reset release
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (done_o == $past(valid_i)));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(valid_i)) |-> $stable(psw_o));

  assert_passthru_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && !trap40_i)) |-> (psw_o == $past(psw_i)));

  assert_mid_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i)) |-> (psw_o[PW-1-NC:AW] == $past(psw_i[PW-1-NC:AW])));

  assert_cc1_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && trap40_i && bad_instr_i)) |-> psw_o[PW-1]);

  assert_no_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && !xinstr_i[AI_BIT])) |-> (psw_o[AW-1:0] == $past(psw_i[AW-1:0])));
endmodule

// File: tb/trap_psw_adjust_tb.sv
module trap_psw_adjust_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] psw_i = '0;
  logic [31:0] xinstr_i = '0;
  logic        trap40_i = 1'b0;
  logic        bad_instr_i = 1'b0, bad_mem_i = 1'b0, priv_i = 1'b0, prot_i = 1'b0;
  logic [31:0] psw_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] exp_psw = '0;
  logic        exp_done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  trap_psw_adjust dut_i (
    .clk_i, .rst_ni, .valid_i, .psw_i, .xinstr_i, .trap40_i,
    .bad_instr_i, .bad_mem_i, .priv_i, .prot_i, .psw_o, .done_o
  );

  function automatic logic [31:0] model(logic [31:0] p, logic t, logic bi, logic bm,
                                        logic pv, logic pr, logic [31:0] ins);
    logic [31:0] r;
    int a;
    r = p;
    if (t) begin
      if (bi) r[31] = 1'b1;
      if (bm) r[30] = 1'b1;
      if (pv) r[29] = 1'b1;
      if (pr) r[28] = 1'b1;
      if (ins[22]) begin
        a = int'(p[16:0]) + 8*int'(bi) + 4*int'(bm) + 2*int'(pv) + int'(pr);
        a = a % 131072;
        r[16:0] = a[16:0];
      end
    end
    return r;
  endfunction

  task automatic check(string tag);
    checks++;
    if (psw_o !== exp_psw) begin
      errors++;
      $display("FAIL %s: psw_o=%h expected %h", tag, psw_o, exp_psw);
    end
    checks++;
    if (done_o !== exp_done) begin
      errors++;
      $display("FAIL %s: done_o=%b expected %b", tag, done_o, exp_done);
    end
  endtask

  // drive after negedge, model updates at posedge, compare at next negedge
  task automatic step(logic v, logic [31:0] p, logic t, logic [3:0] c,
                      logic [31:0] ins, string tag);
    valid_i = v; psw_i = p; trap40_i = t; xinstr_i = ins;
    {bad_instr_i, bad_mem_i, priv_i, prot_i} = c;
    @(posedge clk_i);
    exp_done = v;
    if (v) exp_psw = model(p, t, c[3], c[2], c[1], c[0], ins);
    @(negedge clk_i);
    check(tag);
  endtask

  localparam logic [31:0] AI_SET = 32'h0040_0000;  // bit 9 MSB-first

  initial begin
    #(CLK_PERIOD*100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 after release");

    step(1, 32'h1234_5678, 0, 4'b1111, AI_SET, "R1 passthru");
    step(1, 32'h0000_0100, 1, 4'b1000, AI_SET, "R2 instr ai");
    step(1, 32'h0000_0100, 1, 4'b1000, 32'h0,  "R2 instr no ai");
    step(1, 32'h0000_0100, 1, 4'b0100, AI_SET, "R3 mem ai");
    step(1, 32'h0000_0100, 1, 4'b0010, AI_SET, "R4 priv ai");
    step(1, 32'h0000_0100, 1, 4'b0001, AI_SET, "R5 prot ai");
    step(1, 32'h0000_0100, 1, 4'b1010, AI_SET, "R6 instr+priv adds 10");
    step(1, 32'h0F00_0200, 1, 4'b1111, AI_SET, "R6 all causes");
    step(1, 32'h0000_0300, 1, 4'b1111, ~AI_SET, "R7 other bits ignored");
    step(1, 32'h0000_0300, 1, 4'b0101, AI_SET, "R7 only ai set");
    step(1, 32'h0001_FFFF, 1, 4'b1000, AI_SET, "R8 wrap no carry");
    step(1, 32'h0FFE_FFFE, 1, 4'b1111, AI_SET, "R8 wrap mid bits kept");
    step(0, 32'hDEAD_BEEF, 1, 4'b1111, AI_SET, "R9 hold");
    step(0, 32'h0,         0, 4'b0000, 32'h0,  "R9 hold again");
    step(1, 32'hFFFF_FFFF, 1, 4'b1111, AI_SET, "R9 load");

    for (int i = 0; i < 400; i++) begin
      logic [3:0] c;
      c = 4'($urandom);
      step(1'($urandom), $urandom, 1'($urandom), c, $urandom, "R6 R9 random");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule